// File: doc/BRIEF.md
# Class-Partitioned Virtual Channel Allocator

This block hands out output virtual channels to packet heads that wait in the input virtual channels of a router with `P` ports. Each port carries `V = NMSG × NRES × VPC` virtual channels, grouped by message class and by resource class. A packet stays in one message class for its whole path. It may only step from a nonminimal resource class to the minimal one, never back. The allocator therefore compares each request only against the few output VCs that the packet is permitted to use. This keeps the request matrix small compared with an all-to-all allocator.

Allocation is separable and input-first. Every requesting input VC selects one free, legal output VC on its requested port with a round-robin arbiter. Every output VC then selects one of the inputs that chose it with a second round-robin arbiter. Winners appear as a registered one-cycle grant that carries the global output VC index. A granted output VC is marked busy until a tail-release strobe for it clears the mark.

Top module: `svca_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `gnt_vld` and `ovc_busy` are all zero.
- R2: A grant appears on `gnt_vld[i]` in the cycle after input i requested. `gnt_ovc[i]` then holds the global output VC index `port*V + vc`, and that port equals the `req_port` the input presented.
- R3: The local VC number is `vc = msg*(NRES*VPC) + res*VPC + k`, with msg 0 = request and msg 1 = reply. A grant never joins an input VC and an output VC of different message classes.
- R4: Resource class 0 is nonminimal and class 1 is minimal. An input VC of resource class r only receives output VCs of class r or higher, so a minimal input VC only receives minimal output VCs.
- R5: An output VC whose `ovc_busy` bit is set is never granted. Such a request waits with no grant. A granted output VC shows busy from the grant cycle on.
- R6: In any cycle each output VC is granted to at most one input VC, and competing inputs get exactly one winner.
- R7: A pulse on `tail_rel[o]` while output VC o is busy clears `ovc_busy[o]` at the next edge. A request that is waiting for o is then granted o one cycle after that.
- R8: The arbiters are round-robin and advance only on an accepted grant. The input that won an output VC loses the next contest for the same output VC to another input.
- R9: `gnt_vld[i]` is a single-cycle pulse. A request still held during its grant cycle is ignored and takes no second output VC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | P*V | One request strobe per input VC, held until granted |
| req_port | input | P*V*PW | Requested output port per input VC, PW bits each |
| tail_rel | input | P*V | Tail-departure strobe per output VC, frees it |
| gnt_vld | output | P*V | Registered grant pulse per input VC |
| gnt_ovc | output | P*V*OW | Granted global output VC index per input VC, OW bits each |
| ovc_busy | output | P*V | Ownership flag per output VC |

## Verification
The checker assumes three things about the inputs. A tail release is only signalled for an output VC that is currently busy. `req_port` stays stable while its request is held. A requester deasserts no later than the cycle after its grant pulse, apart from the one cycle that R9 masks. Under these rules the release property and the freedom-from-busy property are meaningful. The bench pulses `tail_rel` only on VCs that it saw granted earlier, and it changes requests only at falling edges, so it never leaves this envelope.

// File: rtl/svca_pkg.sv
package svca_pkg;

  // Message class of a local VC number.
  function automatic int vc_msg(int vc, int nres, int vpc);
    return vc / (nres * vpc);
  endfunction

  // Resource class of a local VC number (0 = nonminimal, higher = more restricted).
  function automatic int vc_res(int vc, int nres, int vpc);
    return (vc / vpc) % nres;
  endfunction

  // An input VC may move to an output VC in the same message class and
  // the same or a later resource class.
  function automatic bit class_ok(int ivc, int ovc, int nres, int vpc);
    return (vc_msg(ivc, nres, vpc) == vc_msg(ovc, nres, vpc)) &&
           (vc_res(ovc, nres, vpc) >= vc_res(ivc, nres, vpc));
  endfunction

endpackage

// File: rtl/svca_rr_arb.sv
module svca_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] win;

  // Scan from the farthest offset back to zero so that the nearest
  // requester at or after the pointer is the one kept.
  always_comb begin
    int idx;
    gnt = '0;
    win = ptr_q;
    for (int k = N - 1; k >= 0; k--) begin
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (req[idx]) begin
        gnt      = '0;
        gnt[idx] = 1'b1;
        win      = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ptr_q <= '0;
    else if (adv)
      ptr_q <= (int'(win) == N - 1) ? '0 : win + 1'b1;
  end

endmodule

// File: rtl/svca_ovc_state.sv
module svca_ovc_state #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] busy
);
  always_ff @(posedge clk) begin
    if (rst)
      busy <= '0;
    else
      busy <= (busy & ~clr) | set;
  end
endmodule

// File: rtl/svca_top.sv
module svca_top #(
  parameter  int P    = 2,
  parameter  int NMSG = 2,
  parameter  int NRES = 2,
  parameter  int VPC  = 2,
  localparam int V    = NMSG * NRES * VPC,
  localparam int NIN  = P * V,
  localparam int NOUT = P * V,
  localparam int PW   = (P > 1) ? $clog2(P) : 1,
  localparam int OW   = (NOUT > 1) ? $clog2(NOUT) : 1
) (
  input  logic [0:0]         clk,
  input  logic [0:0]         rst,
  input  logic [NIN-1:0]     req_vld,
  input  logic [NIN*PW-1:0]  req_port,
  input  logic [NOUT-1:0]    tail_rel,
  output logic [NIN-1:0]     gnt_vld,
  output logic [NIN*OW-1:0]  gnt_ovc,
  output logic [NOUT-1:0]    ovc_busy
);
  logic [NIN-1:0]  req_eff;
  logic [NOUT-1:0] isel  [NIN];
  logic [NIN-1:0]  ocol  [NOUT];
  logic [NIN-1:0]  ogrant[NOUT];
  logic [NOUT-1:0] fgrant[NIN];
  logic [NIN-1:0]  iacc;
  logic [NOUT-1:0] oset;
  logic [OW-1:0]   enc   [NIN];

  // A request is ignored in the cycle its grant is being shown.
  assign req_eff = req_vld & ~gnt_vld;

  // Phase one: each input VC picks one free, legal output VC.
  for (genvar gi = 0; gi < NIN; gi++) begin : g_in
    localparam int IVC = gi % V;
    logic [NOUT-1:0] cand;

    always_comb begin
      for (int o = 0; o < NOUT; o++)
        cand[o] = req_eff[gi] && !ovc_busy[o] &&
                  (o / V == int'(req_port[gi*PW +: PW])) &&
                  svca_pkg::class_ok(IVC, o % V, NRES, VPC);
    end

    svca_rr_arb #(.N(NOUT)) u_iarb (
      .clk (clk),
      .rst (rst),
      .req (cand),
      .adv (iacc[gi]),
      .gnt (isel[gi])
    );
  end

  always_comb begin
    for (int o = 0; o < NOUT; o++)
      for (int i = 0; i < NIN; i++)
        ocol[o][i] = isel[i][o];
  end

  // Phase two: each output VC picks one of the inputs that chose it.
  for (genvar go = 0; go < NOUT; go++) begin : g_out
    svca_rr_arb #(.N(NIN)) u_oarb (
      .clk (clk),
      .rst (rst),
      .req (ocol[go]),
      .adv (oset[go]),
      .gnt (ogrant[go])
    );
  end

  always_comb begin
    for (int o = 0; o < NOUT; o++)
      oset[o] = |ogrant[o];
    for (int i = 0; i < NIN; i++) begin
      enc[i] = '0;
      for (int o = 0; o < NOUT; o++) begin
        fgrant[i][o] = ogrant[o][i];
        if (ogrant[o][i]) enc[i] = OW'(o);
      end
      iacc[i] = |fgrant[i];
    end
  end

  svca_ovc_state #(.N(NOUT)) u_state (
    .clk  (clk),
    .rst  (rst),
    .set  (oset),
    .clr  (tail_rel),
    .busy (ovc_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_vld <= '0;
      gnt_ovc <= '0;
    end else begin
      gnt_vld <= iacc;
      for (int i = 0; i < NIN; i++)
        gnt_ovc[i*OW +: OW] <= enc[i];
    end
  end

endmodule

// File: rtl/svca_chk.sv
module svca_chk #(
  parameter  int P    = 2,
  parameter  int NMSG = 2,
  parameter  int NRES = 2,
  parameter  int VPC  = 2,
  localparam int V    = NMSG * NRES * VPC,
  localparam int NIN  = P * V,
  localparam int NOUT = P * V,
  localparam int PW   = (P > 1) ? $clog2(P) : 1,
  localparam int OW   = (NOUT > 1) ? $clog2(NOUT) : 1
) (
  input logic [0:0]        clk,
  input logic [0:0]        rst,
  input logic [NIN-1:0]    req_vld,
  input logic [NIN*PW-1:0] req_port,
  input logic [NOUT-1:0]   tail_rel,
  input logic [NIN-1:0]    gnt_vld,
  input logic [NIN*OW-1:0] gnt_ovc,
  input logic [NOUT-1:0]   ovc_busy
);
  logic [NOUT-1:0] busy_d;
  logic [NIN-1:0]  owners [NOUT];

  always_ff @(posedge clk) begin
    if (rst) busy_d <= '0;
    else     busy_d <= ovc_busy;
  end

  always_comb begin
    for (int o = 0; o < NOUT; o++)
      for (int i = 0; i < NIN; i++)
        owners[o][i] = gnt_vld[i] && (int'(gnt_ovc[i*OW +: OW]) == o);
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) $past(rst) |-> (gnt_vld == '0 && ovc_busy == '0));

  for (genvar gi = 0; gi < NIN; gi++) begin : g_i
    localparam int IMSG = (gi % V) / (NRES * VPC);
    localparam int IRES = ((gi % V) / VPC) % NRES;
    logic [OW-1:0] ov;
    assign ov = gnt_ovc[gi*OW +: OW];

    // R2
    port_match_chk: assert property (@(posedge clk) disable iff (rst)
      gnt_vld[gi] |-> (int'(ov) / V == int'($past(req_port[gi*PW +: PW]))));
    // R2
    req_before_chk: assert property (@(posedge clk) disable iff (rst)
      gnt_vld[gi] |-> $past(req_vld[gi]));
    // R3
    msg_class_chk: assert property (@(posedge clk) disable iff (rst)
      gnt_vld[gi] |-> ((int'(ov) % V) / (NRES * VPC) == IMSG));
    // R4
    res_class_chk: assert property (@(posedge clk) disable iff (rst)
      gnt_vld[gi] |-> (((int'(ov) % V) / VPC) % NRES >= IRES));
    // R5
    was_free_chk: assert property (@(posedge clk) disable iff (rst)
      gnt_vld[gi] |-> !busy_d[ov]);
    // R5
    now_busy_chk: assert property (@(posedge clk) disable iff (rst)
      gnt_vld[gi] |-> ovc_busy[ov]);
    // R9
    pulse_chk: assert property (@(posedge clk) disable iff (rst)
      gnt_vld[gi] |=> !gnt_vld[gi]);
  end

  for (genvar go = 0; go < NOUT; go++) begin : g_o
    // R6
    one_owner_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(owners[go]));
    // R7
    release_chk: assert property (@(posedge clk) disable iff (rst)
      $past(tail_rel[go] && ovc_busy[go]) |-> !ovc_busy[go]);
  end

endmodule

bind svca_top svca_chk #(.P(P), .NMSG(NMSG), .NRES(NRES), .VPC(VPC)) i_chk (.*);

// File: tb/test_svca_top.sv
`timescale 1ns/1ps
module test_svca_top;
  localparam int P = 2, V = 8, NIN = 16, NOUT = 16, PW = 1, OW = 4;

  logic              clk = 1'b0;
  logic              rst;
  logic [NIN-1:0]    req_vld;
  logic [NIN*PW-1:0] req_port;
  logic [NOUT-1:0]   tail_rel;
  logic [NIN-1:0]    gnt_vld;
  logic [NIN*OW-1:0] gnt_ovc;
  logic [NOUT-1:0]   ovc_busy;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  svca_top #(.P(P), .NMSG(2), .NRES(2), .VPC(2)) i_svca_top (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_port(req_port),
    .tail_rel(tail_rel), .gnt_vld(gnt_vld), .gnt_ovc(gnt_ovc), .ovc_busy(ovc_busy)
  );

  // {input VC, output port, VC to release first (-1 none), expected output VC}
  localparam int TBL [12][4] = '{
    '{0, 1, -1, 8},  '{0, 1, -1, 9},  '{2, 1, -1, 10}, '{4, 1, -1, 12},
    '{14, 0, -1, 6}, '{3, 1, -1, 11}, '{1, 1, 9, 9},   '{0, 1, 10, 10},
    '{8, 0, -1, 0},  '{15, 0, -1, 7}, '{13, 0, -1, 4}, '{5, 0, -1, 5}
  };

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int ovc_of(int i);
    return int'(gnt_ovc[i*OW +: OW]);
  endfunction

  task automatic ask(int i, int port);
    req_vld[i] = 1'b1;
    req_port[i*PW +: PW] = PW'(port);
  endtask

  task automatic release_vc(int o);
    tail_rel[o] = 1'b1;
    @(negedge clk);
    tail_rel = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_vld = '0; req_port = '0; tail_rel = '0;
    repeat (4) @(negedge clk);
    chk("R1 grants idle in reset", 32'(gnt_vld), 0);
    chk("R1 busy clear in reset", 32'(ovc_busy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 grants idle after reset", 32'(gnt_vld), 0);

    // Vector walk: single requests against accumulating ownership state.
    for (int t = 0; t < 12; t++) begin
      if (TBL[t][2] >= 0) begin
        release_vc(TBL[t][2]);
        chk("R7 released VC free", 32'(ovc_busy[TBL[t][2]]), 0);
      end
      ask(TBL[t][0], TBL[t][1]);
      @(negedge clk);
      chk("R6 sole grant line", 32'(gnt_vld), 32'(1) << TBL[t][0]);
      chk("R2 R3 R4 granted VC", ovc_of(TBL[t][0]), TBL[t][3]);
      chk("R5 granted VC busy", 32'(ovc_busy[TBL[t][3]]), 1);
      req_vld[TBL[t][0]] = 1'b0;
      @(negedge clk);
      chk("R9 grant pulse ends", 32'(gnt_vld), 0);
    end

    // R5: every candidate busy, request waits; R7: release lets it in.
    ask(8, 1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R5 no grant while candidates busy", 32'(gnt_vld), 0);
    end
    tail_rel[11] = 1'b1;
    @(negedge clk);
    tail_rel = '0;
    chk("R7 no grant in release cycle", 32'(gnt_vld), 0);
    chk("R7 VC 11 freed", 32'(ovc_busy[11]), 0);
    @(negedge clk);
    chk("R7 waiting input granted", 32'(gnt_vld), 32'(1) << 8);
    chk("R7 freed VC regranted", ovc_of(8), 11);
    req_vld[8] = 1'b0;
    @(negedge clk);

    // R9: request held through the grant cycle takes nothing more.
    ask(9, 0);
    @(negedge clk);
    chk("R9 first grant line", 32'(gnt_vld), 32'(1) << 9);
    chk("R9 first grant VC", ovc_of(9), 1);
    @(negedge clk);
    chk("R9 held request ignored", 32'(gnt_vld), 0);
    chk("R9 no second VC taken", 32'(ovc_busy[2]), 0);
    req_vld[9] = 1'b0;
    @(negedge clk);

    // R6: two inputs aim at the same VC, one wins, the other gets the next.
    ask(10, 0);
    ask(11, 0);
    @(negedge clk);
    chk("R6 single winner", 32'(gnt_vld), 32'(1) << 10);
    chk("R6 winner VC", ovc_of(10), 2);
    req_vld[10] = 1'b0;
    @(negedge clk);
    chk("R6 loser served next", 32'(gnt_vld), 32'(1) << 11);
    chk("R6 loser VC", ovc_of(11), 3);
    req_vld[11] = 1'b0;
    @(negedge clk);

    // R8: rematch for VC 2, previous winner now loses.
    release_vc(2);
    ask(10, 0);
    ask(11, 0);
    @(negedge clk);
    chk("R8 rotation winner", 32'(gnt_vld), 32'(1) << 11);
    chk("R8 rotation VC", ovc_of(11), 2);
    req_vld[11] = 1'b0;
    @(negedge clk);
    chk("R8 previous winner waits", 32'(gnt_vld), 0);
    req_vld = '0;
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule